// File: doc/BRIEF.md
# Constant-Linear-Velocity Spindle Phase Controller

This block keeps a disc spindle locked to a crystal-derived frame rate. A free-running reference counter divides the system clock into reference frames. Each frame-sync strobe from the playback side captures the counter position, and that position is read as a signed phase error. A playback frame that arrives late asks for more speed. A playback frame that arrives early asks for less.

The motor command is one three-state output, modelled as a data bit plus an output enable. Drive high means accelerate, drive low means decelerate, and released (high impedance) means hold. After each strobe the output is driven for as many clock cycles as the size of the phase error. Small errors inside a dead band are ignored. When strobes stop arriving for several reference frames, the block kicks the motor with a steady accelerate until sync returns. A stop request brakes the motor with a steady decelerate. A low enable releases the output and clears all timing state.

All inputs are synchronous to the system clock. The strobe is a single-cycle pulse. The pins are plain control signals and have no handshake.

Top module: `clv_spindle_ctrl`

## Requirements
- R1: The reference position counts 0 to FRAME_CYC-1 (default 2352) and wraps. A strobe that samples position p has a lag of p when p < FRAME_CYC/2, and a lead of FRAME_CYC-p otherwise.
- R2: With a lag above the dead band, the output drives high (motor_oe=1, motor_drive=1) for exactly lag cycles. The pulse starts in the cycle after the strobe.
- R3: With a lead above the dead band, the output drives low (motor_oe=1, motor_drive=0) for exactly lead cycles. The pulse starts in the cycle after the strobe.
- R4: An error of DEAD_BAND (default 4) cycles or less leaves the output released (motor_oe=0).
- R5: A pulse never lasts more than MAX_PULSE cycles (default FRAME_CYC/2). A lead at p=FRAME_CYC/2 gives a low pulse of exactly FRAME_CYC/2 cycles.
- R6: After LOST_FRAMES (default 8) reference wraps pass with no strobe, the output drives high continuously, starting from the edge that ends the last such frame. The next strobe ends this kick and applies its own phase error.
- R7: While enable is low, the output is released from the next edge and all counters are cleared. After enable rises, the first edge samples reference position 0.
- R8: While stop is high with enable high, the output drives low from the next edge. This overrides pulses and kick, and the lost-frame count is held cleared. Releasing stop returns the output to released at the next edge.
- R9: During and after reset the output is released with motor_drive=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Servo enable; low releases the output and clears state |
| stop | input | 1 | Brake request; drives decelerate continuously |
| fsync | input | 1 | Single-cycle playback frame-sync strobe |
| motor_drive | output | 1 | Motor command level, 1 accelerate, 0 decelerate |
| motor_oe | output | 1 | Output enable; 0 means high impedance (hold) |

## Verification
A reference counter that drifts from the true position shows up as pulse widths that are off by the drift on the very first strobe. A wrong lag/lead split flips the drive level for positions near half a frame. A lost-frame counter that counts wrong kicks either one frame early or one frame late, so the check looks at the exact edge. A pulse counter that is not cleared by enable or stop leaves the output driven for at least one cycle after the next edge, where the bench samples it.

// File: rtl/clv_pkg.sv
package clv_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_ACCEL = 2'd1,
    CMD_DECEL = 2'd2
  } motor_cmd_e;
endpackage

// File: rtl/clv_ref_timer.sv
module clv_ref_timer #(
  parameter int FRAME_CYC = 2352,
  parameter int CW        = $clog2(FRAME_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] ref_pos,
  output logic          ref_wrap
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ref_pos <= '0;
    else if (!run)         ref_pos <= '0;
    else if (ref_pos == LAST) ref_pos <= '0;
    else                   ref_pos <= ref_pos + 1'b1;
  end

  assign ref_wrap = run && (ref_pos == LAST);
endmodule

// File: rtl/clv_phase_detect.sv
module clv_phase_detect #(
  parameter int FRAME_CYC = 2352,
  parameter int DEAD_BAND = 4,
  parameter int MAX_PULSE = FRAME_CYC / 2,
  parameter int CW        = $clog2(FRAME_CYC + 1)
) (
  input  logic [CW-1:0] ref_pos,
  output logic          lag,
  output logic          in_band,
  output logic [CW-1:0] pulse_len
);
  localparam int HALF = FRAME_CYC / 2;
  logic [CW-1:0] mag;
  logic [CW-1:0] clamped;

  always_comb begin
    if (ref_pos < CW'(HALF)) begin
      lag = 1'b1;
      mag = ref_pos;
    end else begin
      lag = 1'b0;
      mag = CW'(FRAME_CYC) - ref_pos;
    end
  end

  generate
    if (MAX_PULSE >= FRAME_CYC - HALF) begin : g_noclamp
      assign clamped = mag;
    end else begin : g_clamp
      assign clamped = (mag > CW'(MAX_PULSE)) ? CW'(MAX_PULSE) : mag;
    end
  endgenerate

  assign in_band   = (mag <= CW'(DEAD_BAND));
  assign pulse_len = in_band ? '0 : clamped;
endmodule

// File: rtl/clv_pulse_gen.sv
module clv_pulse_gen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  input  logic          load_lag,
  output logic          active,
  output logic          lag
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      lag    <= 1'b0;
    end else if (clr) begin
      remain <= '0;
      lag    <= 1'b0;
    end else if (load) begin
      remain <= load_len;
      lag    <= load_lag;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign active = (remain != '0);
endmodule

// File: rtl/clv_lock_watch.sv
module clv_lock_watch #(
  parameter int LOST_FRAMES = 8,
  parameter int MW          = $clog2(LOST_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fsync,
  input  logic ref_wrap,
  output logic kick
);
  localparam logic [MW-1:0] LIMIT = MW'(LOST_FRAMES);
  logic [MW-1:0] missed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        missed <= '0;
    else if (clr || fsync)             missed <= '0;
    else if (ref_wrap && missed != LIMIT) missed <= missed + 1'b1;
  end

  assign kick = (missed == LIMIT);
endmodule

// File: rtl/clv_spindle_ctrl.sv
module clv_spindle_ctrl #(
  parameter int FRAME_CYC   = 2352,
  parameter int DEAD_BAND   = 4,
  parameter int LOST_FRAMES = 8,
  parameter int MAX_PULSE   = FRAME_CYC / 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic stop,
  input  logic fsync,
  output logic motor_drive,
  output logic motor_oe
);
  import clv_pkg::*;

  localparam int CW = $clog2(FRAME_CYC + 1);

  logic [CW-1:0] ref_pos;
  logic          ref_wrap;
  logic          det_lag;
  logic          in_band;
  logic [CW-1:0] pulse_len;
  logic          pulse_active;
  logic          pulse_lag;
  logic          kick;
  logic          brake_q;
  logic          hold_clr;
  logic          sync_ok;
  motor_cmd_e    cmd;

  assign hold_clr = !enable || stop;
  assign sync_ok  = enable && !stop && fsync;

  clv_ref_timer #(.FRAME_CYC(FRAME_CYC), .CW(CW)) u_ref (
    .clk(clk), .rst_n(rst_n), .run(enable),
    .ref_pos(ref_pos), .ref_wrap(ref_wrap)
  );

  clv_phase_detect #(.FRAME_CYC(FRAME_CYC), .DEAD_BAND(DEAD_BAND),
                     .MAX_PULSE(MAX_PULSE), .CW(CW)) u_det (
    .ref_pos(ref_pos), .lag(det_lag), .in_band(in_band), .pulse_len(pulse_len)
  );

  clv_pulse_gen #(.CW(CW)) u_pulse (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr), .load(sync_ok),
    .load_len(pulse_len), .load_lag(det_lag),
    .active(pulse_active), .lag(pulse_lag)
  );

  clv_lock_watch #(.LOST_FRAMES(LOST_FRAMES)) u_lock (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr), .fsync(sync_ok),
    .ref_wrap(ref_wrap), .kick(kick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brake_q <= 1'b0;
    else        brake_q <= enable && stop;
  end

  always_comb begin
    if (brake_q)           cmd = CMD_DECEL;
    else if (kick)         cmd = CMD_ACCEL;
    else if (pulse_active) cmd = pulse_lag ? CMD_ACCEL : CMD_DECEL;
    else                   cmd = CMD_HOLD;
  end

  assign motor_oe    = (cmd != CMD_HOLD);
  assign motor_drive = (cmd == CMD_ACCEL);
endmodule

// File: rtl/clv_spindle_ctrl_chk.sv
module clv_spindle_ctrl_chk #(
  parameter int MAX_PULSE = 1176
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic stop,
  input logic fsync,
  input logic motor_drive,
  input logic motor_oe,
  input logic kick,
  input logic brake_q,
  input logic in_band
);
  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= 0;
    else if (fsync || brake_q || !(motor_oe && !motor_drive)) low_run <= 0;
    else low_run <= low_run + 1;
  end

  // R5
  pulse_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= MAX_PULSE);

  // R4
  dead_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !stop && fsync && in_band) |=> !motor_oe);

  // R6
  kick_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !brake_q) |-> (motor_oe && motor_drive));

  // R6
  kick_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !stop && fsync) |=> !kick);

  // R7
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !motor_oe);

  // R8
  brake_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stop) |=> (motor_oe && !motor_drive));
endmodule

bind clv_spindle_ctrl clv_spindle_ctrl_chk #(.MAX_PULSE(MAX_PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .stop(stop), .fsync(fsync),
  .motor_drive(motor_drive), .motor_oe(motor_oe), .kick(kick),
  .brake_q(brake_q), .in_band(in_band)
);

// File: tb/clv_spindle_ctrl_test.sv
module clv_spindle_ctrl_test;
  localparam int N    = 2352;
  localparam int HALF = N / 2;
  localparam int NV   = 10;
  // sampled position, expected level (1 high / 0 low), expected width
  localparam int VPOS[NV] = '{0, 4, 5, 100, 1175, 1176, 2348, 2347, 2000, 2351};
  localparam int VLVL[NV] = '{0, 1, 1, 1,   1,    0,    0,    0,    0,    0};
  localparam int VWID[NV] = '{0, 0, 5, 100, 1175, 1176, 0,    5,    352,  0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic stop = 1'b0;
  logic fsync = 1'b0;
  logic motor_drive;
  logic motor_oe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clv_spindle_ctrl uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .stop(stop), .fsync(fsync),
    .motor_drive(motor_drive), .motor_oe(motor_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk) begin enable = 1'b0; stop = 1'b0; fsync = 1'b0; end
    @(negedge clk) enable = 1'b1;
  endtask

  task automatic strobe_at(input int pos);
    restart();
    repeat (pos) @(negedge clk);
    fsync = 1'b1;
    @(negedge clk) fsync = 1'b0;
  endtask

  task automatic run_vec(input int pos, input int lvl, input int w, input string tag);
    int cnt = 0;
    bit bad = 1'b0;
    strobe_at(pos);
    while (motor_oe && cnt < 3000) begin
      if (motor_drive != lvl[0]) bad = 1'b1;
      cnt++;
      @(negedge clk);
    end
    check(cnt == w && !bad, tag, cnt, w);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!motor_oe && !motor_drive, "R9 in reset", {motor_oe, motor_drive}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!motor_oe, "R9 after reset disabled", motor_oe, 0);

    // table walk: R1 error derivation, R2 lag, R3 lead, R4 band, R5 clamp
    for (int i = 0; i < NV; i++) begin
      string tag;
      if (VPOS[i] == HALF)  tag = "R5 clamp at half frame";
      else if (VWID[i] == 0) tag = "R4 dead band";
      else if (VLVL[i] == 1) tag = "R2 lag pulse (R1)";
      else                   tag = "R3 lead pulse (R1)";
      run_vec(VPOS[i], VLVL[i], VWID[i], tag);
    end

    // R6 kick after lost frames, exact edge
    restart();
    repeat (8 * N - 1) @(negedge clk);
    check(!motor_oe, "R6 no kick one cycle early", motor_oe, 0);
    @(negedge clk);
    check(motor_oe && motor_drive, "R6 kick drives high", {motor_oe, motor_drive}, 3);
    fsync = 1'b1;
    @(negedge clk) fsync = 1'b0;
    check(!motor_oe, "R6 strobe ends kick", motor_oe, 0);

    // R7 enable low mid-pulse, then restart from position 0
    strobe_at(HALF);
    repeat (10) @(negedge clk);
    check(motor_oe && !motor_drive, "R3 lead pulse running", {motor_oe, motor_drive}, 2);
    enable = 1'b0;
    @(negedge clk);
    check(!motor_oe, "R7 disable releases output", motor_oe, 0);
    repeat (N) @(negedge clk);
    check(!motor_oe, "R7 stays released", motor_oe, 0);
    run_vec(100, 1, 100, "R7 restart from position 0");

    // R8 brake
    strobe_at(100);
    repeat (10) @(negedge clk);
    check(motor_oe && motor_drive, "R2 lag pulse running", {motor_oe, motor_drive}, 3);
    stop = 1'b1;
    @(negedge clk);
    check(motor_oe && !motor_drive, "R8 brake overrides pulse", {motor_oe, motor_drive}, 2);
    repeat (9 * N) @(negedge clk);
    check(motor_oe && !motor_drive, "R8 brake overrides kick", {motor_oe, motor_drive}, 2);
    stop = 1'b0;
    @(negedge clk);
    check(!motor_oe, "R8 release returns to hold", motor_oe, 0);
    repeat (2 * N) @(negedge clk);
    check(!motor_oe, "R8 lost count cleared", motor_oe, 0);
    enable = 1'b0;
    stop = 1'b1;
    @(negedge clk);
    check(!motor_oe, "R7 disable beats stop", motor_oe, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule